// File: doc/BRIEF.md
# Mode Register and Program-Word Read Unit

This unit holds a 4-bit MODE register and carries out the four instructions that move values between MODE, the 8-bit working register W and the 12-bit program memory. It decodes a 12-bit instruction word. A literal can be loaded into MODE. MODE can be copied into W, and the low nibble of W can be copied into MODE. A program word can be fetched, using MODE as the upper four address bits and W as the lower eight.

A fetched word comes back split across the same pair of registers: bits 11:8 go to MODE and bits 7:0 go to W. The fetch keeps the unit busy for a fixed `READ_CYCLES` window. This window has no dependence on the speed mode the core runs in, and the block has no input for it. MODE and the W write-back land on the same clock edge. The core owns W. It presents the current value on `w_in` and takes a write through `w_we`/`w_data`. None of the operations touches a status flag.

Top module: `modeunit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, MODE reads 0, and `busy`, `w_we` and `mem_rd_en` are all 0.
- R2: An accepted word whose bits 11:4 are 0x05 loads bits 3:0 into MODE on the accepting edge, without raising `busy` or `w_we`.
- R3: An accepted word 0x042 raises `w_we` in the same cycle, with `w_data` equal to `{4'b0000, MODE}`.
- R4: An accepted word 0x043 loads `w_in[3:0]` into MODE on the accepting edge, and `w_we` stays 0.
- R5: An accepted word 0x041 starts a fetch. In the first cycle after the accepting edge, `mem_rd_en` pulses for one cycle with `mem_addr = {MODE, w_in}`, using the values that were present at acceptance.
- R6: After a fetch is accepted, `busy` stays high for exactly `READ_CYCLES` cycles (`READ_CYCLES` is at least 3). In the last of these cycles, `w_we` is high with `w_data` equal to bits 7:0 of the fetched word, and at the edge that closes that cycle MODE takes bits 11:8.
- R7: The fetch window is the same length for every fetch, whatever the address and whatever words come before it.
- R8: While `busy` is high, instructions are ignored: MODE changes only at the end of the fetch, and no extra W write occurs.
- R9: Any other instruction word (for example 0x000, 0x044, 0x06x) is ignored: MODE is unchanged and `w_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 12 | Instruction word |
| w_in | input | 8 | Current value of W |
| w_we | output | 1 | Write strobe for W |
| w_data | output | 8 | Value to write into W |
| mode | output | 4 | MODE register |
| busy | output | 1 | A fetch is in progress |
| mem_rd_en | output | 1 | Program-memory read request |
| mem_addr | output | 12 | Program-memory address |
| mem_rd_data | input | 12 | Program-memory data, valid one cycle after the request |

## Verification
The results do not all arrive on the same cycle. A copy into W appears combinationally in the cycle the instruction is presented. MODE loads are visible the cycle after the accepting edge. The memory request appears one cycle after acceptance, and the fetched word is written back in cycle `READ_CYCLES` after acceptance, with the MODE half visible one cycle later. The bench drives inputs just after a rising edge and samples on the falling edge. Expected W writes are queued before their instruction is driven, and a monitor pairs each observed `w_we` with the head of that queue. This catches both missing and unexpected writes. The busy window is counted cycle by cycle, and its length is compared to `READ_CYCLES` for several addresses, including a fetch that has an ignored instruction held over it.

// File: rtl/modeunit_pkg.sv
package modeunit_pkg;
    localparam int MODE_W  = 4;
    localparam int DATA_W  = 8;
    localparam int WORD_W  = MODE_W + DATA_W;
    localparam int INSTR_W = 12;

    localparam logic [INSTR_W-1:0] ENC_MODE_TO_W = 12'h042;
    localparam logic [INSTR_W-1:0] ENC_W_TO_MODE = 12'h043;
    localparam logic [INSTR_W-1:0] ENC_FETCH     = 12'h041;
    localparam logic [INSTR_W-MODE_W-1:0] ENC_LIT_PREFIX = 8'h05;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LIT,
        OP_MODE_TO_W,
        OP_W_TO_MODE,
        OP_FETCH
    } op_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
    } regs_t;
endpackage

// File: rtl/modeunit_dec.sv
module modeunit_dec
    import modeunit_pkg::*;
(
    input  logic               valid,
    input  logic [INSTR_W-1:0] word,
    output op_e                op
);
    always_comb begin
        op = OP_NONE;
        if (valid) begin
            if (word[INSTR_W-1:MODE_W] == ENC_LIT_PREFIX) begin
                op = OP_LIT;
            end else if (word == ENC_MODE_TO_W) begin
                op = OP_MODE_TO_W;
            end else if (word == ENC_W_TO_MODE) begin
                op = OP_W_TO_MODE;
            end else if (word == ENC_FETCH) begin
                op = OP_FETCH;
            end
        end
    end
endmodule

// File: rtl/modeunit_rdseq.sv
module modeunit_rdseq
    import modeunit_pkg::*;
#(
    parameter int READ_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] addr_in,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [WORD_W-1:0] mem_addr,
    output logic              done,
    output logic [WORD_W-1:0] done_word
);
    localparam int CW = (READ_CYCLES > 2) ? $clog2(READ_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_FIRST   = CW'(READ_CYCLES - 1);
    localparam logic [CW-1:0] CNT_CAPTURE = CW'(READ_CYCLES - 2);
    localparam logic [CW-1:0] CNT_LAST    = '0;

    typedef struct packed {
        logic              busy;
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy = 1'b1;
                seq_d.cnt  = CNT_FIRST;
                seq_d.addr = addr_in;
            end
        end else begin
            if (seq_q.cnt == CNT_CAPTURE) begin
                seq_d.data = mem_rd_data;
            end
            if (seq_q.cnt == CNT_LAST) begin
                seq_d.busy = 1'b0;
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = seq_q.busy;
    assign mem_rd_en = seq_q.busy && (seq_q.cnt == CNT_FIRST);
    assign mem_addr  = seq_q.addr;
    assign done      = seq_q.busy && (seq_q.cnt == CNT_LAST);
    assign done_word = seq_q.data;
endmodule

// File: rtl/modeunit.sv
module modeunit
    import modeunit_pkg::*;
#(
    parameter int READ_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  w_in,
    output logic               w_we,
    output logic [DATA_W-1:0]  w_data,
    output logic [MODE_W-1:0]  mode,
    output logic               busy,
    output logic               mem_rd_en,
    output logic [WORD_W-1:0]  mem_addr,
    input  logic [WORD_W-1:0]  mem_rd_data
);
    op_e               op;
    logic              seq_busy;
    logic              seq_done;
    logic [WORD_W-1:0] seq_word;
    logic              fetch_start;
    regs_t             regs_d, regs_q;

    modeunit_dec u_dec (
        .valid (instr_valid && !seq_busy),
        .word  (instr),
        .op    (op)
    );

    assign fetch_start = (op == OP_FETCH);

    modeunit_rdseq #(.READ_CYCLES(READ_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (fetch_start),
        .addr_in     ({regs_q.mode, w_in}),
        .mem_rd_data (mem_rd_data),
        .busy        (seq_busy),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .done        (seq_done),
        .done_word   (seq_word)
    );

    always_comb begin
        regs_d = regs_q;
        w_we   = 1'b0;
        w_data = {{(DATA_W-MODE_W){1'b0}}, regs_q.mode};
        if (seq_done) begin
            regs_d.mode = seq_word[WORD_W-1:DATA_W];
            w_we        = 1'b1;
            w_data      = seq_word[DATA_W-1:0];
        end else begin
            case (op)
                OP_LIT:       regs_d.mode = instr[MODE_W-1:0];
                OP_W_TO_MODE: regs_d.mode = w_in[MODE_W-1:0];
                OP_MODE_TO_W: w_we = 1'b1;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mode = regs_q.mode;
    assign busy = seq_busy;
endmodule

// File: rtl/modeunit_chk.sv
module modeunit_chk
    import modeunit_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr,
    input logic [DATA_W-1:0]  w_in,
    input logic               w_we,
    input logic [DATA_W-1:0]  w_data,
    input logic [MODE_W-1:0]  mode,
    input logic               busy,
    input logic               mem_rd_en,
    input logic [WORD_W-1:0]  mem_addr
);
    logic take;
    logic is_lit, is_m2w, is_w2m, is_rd;
    assign take   = instr_valid && !busy;
    assign is_lit = take && (instr[INSTR_W-1:MODE_W] == ENC_LIT_PREFIX);
    assign is_m2w = take && (instr == ENC_MODE_TO_W);
    assign is_w2m = take && (instr == ENC_W_TO_MODE);
    assign is_rd  = take && (instr == ENC_FETCH);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (mode == '0) && !busy && !mem_rd_en);

    a_r2_lit_load: assert property (@(posedge clk) disable iff (!rst_n)
        is_lit |=> (mode == $past(instr[MODE_W-1:0])) && !busy);

    a_r3_mode_to_w: assert property (@(posedge clk) disable iff (!rst_n)
        is_m2w |-> w_we && (w_data == {{(DATA_W-MODE_W){1'b0}}, mode}));

    a_r4_w_to_mode: assert property (@(posedge clk) disable iff (!rst_n)
        is_w2m |=> mode == $past(w_in[MODE_W-1:0]));

    a_r4_no_w_write: assert property (@(posedge clk) disable iff (!rst_n)
        (is_w2m || is_lit) |-> !w_we);

    a_r5_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> busy && mem_rd_en && (mem_addr == $past({mode, w_in})));

    a_r5_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    a_r6_write_ends_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && w_we) |=> !busy);

    a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !w_we) |=> $stable(mode));

    a_r9_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !is_lit && !is_m2w && !is_w2m && !is_rd) |=> $stable(mode) && !busy);
endmodule

bind modeunit modeunit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .w_in        (w_in),
    .w_we        (w_we),
    .w_data      (w_data),
    .mode        (mode),
    .busy        (busy),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr)
);

// File: tb/modeunit_test.sv
module modeunit_test;
    localparam int RC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [11:0] instr = '0;
    logic [7:0]  w_reg = 8'hC7;
    logic        w_we;
    logic [7:0]  w_data;
    logic [3:0]  mode;
    logic        busy;
    logic        mem_rd_en;
    logic [11:0] mem_addr;
    logic [11:0] mem_rd_data = '0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] expq[$];
    logic [3:0] mode_exp = '0;

    always #5 clk = ~clk;

    modeunit #(.READ_CYCLES(RC)) uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .w_in(w_reg), .w_we(w_we), .w_data(w_data), .mode(mode), .busy(busy),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
    );

    function automatic logic [11:0] romf(input logic [11:0] a);
        return 12'(a * 12'd37 + 12'h5A3);
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= romf(mem_addr);
        if (rst_n && w_we) w_reg <= w_data;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: each W write must match the head of the expectation queue
    always @(negedge clk) begin
        if (rst_n && w_we) begin
            if (expq.size() == 0) begin
                check("R9 unexpected W write", {24'd0, w_data}, 32'hFFFF_FFFF);
            end else begin
                check("R3/R6 W write data", {24'd0, w_data}, {24'd0, expq.pop_front()});
            end
        end
    end

    task automatic one_op(input logic [11:0] word);
        @(posedge clk); #1;
        instr = word; instr_valid = 1'b1;
        @(posedge clk); #1;
        instr_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic fetch(input bit inject, input string req);
        logic [11:0] a;
        logic [11:0] d;
        int cyc;
        a = {mode_exp, w_reg};
        d = romf(a);
        expq.push_back(d[7:0]);
        @(posedge clk); #1;
        instr = 12'h041; instr_valid = 1'b1;
        @(posedge clk); #1;
        if (inject) instr = 12'h05F; else instr_valid = 1'b0;
        cyc = 0;
        for (int g = 0; g < 40; g++) begin
            @(negedge clk);
            if (!busy) break;
            cyc++;
            if (cyc == 1) begin
                check("R5 read strobe", {31'd0, mem_rd_en}, 32'd1);
                check("R5 address", {20'd0, mem_addr}, {20'd0, a});
            end else begin
                check("R5 single strobe", {31'd0, mem_rd_en}, 32'd0);
            end
            if (cyc < RC) check("R8 mode held while busy", {28'd0, mode}, {28'd0, mode_exp});
        end
        instr_valid = 1'b0;
        check({req, " busy length"}, cyc, RC);
        mode_exp = d[11:8];
        check("R6 mode high nibble", {28'd0, mode}, {28'd0, mode_exp});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 mode in reset", {28'd0, mode}, 32'd0);
        check("R1 busy in reset", {31'd0, busy}, 32'd0);
        check("R1 w_we in reset", {31'd0, w_we}, 32'd0);
        check("R1 rd_en in reset", {31'd0, mem_rd_en}, 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 mode after reset", {28'd0, mode}, 32'd0);

        one_op(12'h059); mode_exp = 4'h9;
        check("R2 literal load", {28'd0, mode}, {28'd0, mode_exp});
        check("R2 no busy", {31'd0, busy}, 32'd0);

        expq.push_back({4'h0, mode_exp});
        one_op(12'h042);
        check("R3 W after copy", {24'd0, w_reg}, 32'h09);

        one_op(12'h05A); mode_exp = 4'hA;
        one_op(12'h043); mode_exp = w_reg[3:0];
        check("R4 W low nibble to mode", {28'd0, mode}, {28'd0, mode_exp});

        one_op(12'h000);
        check("R9 0x000 ignored", {28'd0, mode}, {28'd0, mode_exp});
        one_op(12'h044);
        check("R9 0x044 ignored", {28'd0, mode}, {28'd0, mode_exp});
        one_op(12'h065);
        check("R9 0x065 ignored", {28'd0, mode}, {28'd0, mode_exp});

        one_op(12'h053); mode_exp = 4'h3;
        fetch(1'b0, "R6");
        check("R6 W low byte", {24'd0, w_reg}, {24'd0, romf({4'h3, 8'h09})} & 32'hFF);
        fetch(1'b1, "R8");
        one_op(12'h05F); mode_exp = 4'hF;
        expq.push_back({4'h0, mode_exp});
        one_op(12'h042);
        fetch(1'b0, "R7");
        one_op(12'h050); mode_exp = 4'h0;
        fetch(1'b0, "R7");

        repeat (3) @(negedge clk);
        check("R3/R6 all W writes seen", expq.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule